// File: doc/BRIEF.md
# Up/Down Route Legality Checker

This block watches a source-routed path one hop at a time and decides whether the path respects the up/down deadlock-avoidance rule used on irregular switch networks. Each hop names the switch it leaves and the switch it enters. For both ends it carries the switch identifier, its spanning-tree level and its label. From these the block classifies the hop as going "up" or "down". A run-time mode input selects one of two direction schemes. One scheme uses tree level, with the identifier breaking ties. The other uses label order.

A path is framed by a start pulse and an end pulse. Between them the block keeps one sticky bit that records whether a down hop has occurred, and one sticky bit that records a violation. The cycle after the end pulse, it raises a one-cycle done pulse together with the verdict. Building the spanning tree and producing the routes are done elsewhere.

Top module: `updown_route_checker`

## Requirements
- R1: `path_start` discards all state of the previous path, so the new path begins with no down hop and no violation recorded.
- R2: With `dir_mode`=0 (level scheme), a hop is up when the entered switch has a strictly smaller level than the left switch, and down when its level is strictly larger.
- R3: With `dir_mode`=0 and equal levels, a hop is up when the entered switch has a strictly smaller identifier; equal identifiers count as down.
- R4: With `dir_mode`=1 (label scheme), a hop is up when the entered switch has a strictly higher label (unsigned compare), otherwise down.
- R5: A path made of any number of up hops followed by any number of down hops is legal. An up hop occurring after any down hop of the same path makes it illegal.
- R6: Once a path is illegal, it stays illegal whatever hops follow, until the next `path_start`.
- R7: A path with no hops is reported legal.
- R8: `done` is high for exactly the one cycle after each `path_end`. `legal` is updated in that same cycle and holds its value until the next `done`.
- R9: A hop given in the same cycle as `path_end` is part of the ending path. A hop given in the same cycle as `path_start` is the first hop of the new path.
- R10: After reset, `done` and `legal` are 0 and no down hop or violation is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_mode | input | 1 | 0: level scheme, 1: label scheme |
| path_start | input | 1 | Opens a new path |
| hop_valid | input | 1 | A hop is presented this cycle |
| src_id | input | ID_W | Identifier of the switch being left |
| dst_id | input | ID_W | Identifier of the switch being entered |
| src_lvl | input | LVL_W | Tree level of the switch being left |
| dst_lvl | input | LVL_W | Tree level of the switch being entered |
| src_lbl | input | LBL_W | Label of the switch being left |
| dst_lbl | input | LBL_W | Label of the switch being entered |
| path_end | input | 1 | Closes the current path |
| legal | output | 1 | Verdict of the last closed path |
| done | output | 1 | One-cycle pulse, verdict valid |

## Verification
Only the verdict of a closed path exposes the internal state. A wrongly set or lost down bit therefore shows up as a wrong `legal` at the first path that contains a later up hop. A violation bit that is not sticky shows up only when more hops follow the bad one. Both faults become visible one cycle after `path_end`. The bench runs every direction decision through a two-hop path whose first hop is a known down hop, so each misclassification flips a verdict. Directed paths cover stickiness, zero-hop paths and hops that coincide with the framing pulses.

// File: rtl/udr_pkg.sv
// Package: shared direction type for the up/down route checker.
// Assumes: nothing beyond IEEE 1800-2017.
package udr_pkg;
    typedef enum logic {
        HOP_DOWN = 1'b0,
        HOP_UP   = 1'b1
    } hop_dir_e;
endpackage

// File: rtl/udr_hop_classify.sv
// Module: udr_hop_classify
// Decides, combinationally, whether one hop travels up or down.
// Level scheme: the up end is the smaller level, and on equal levels the
// smaller identifier. Label scheme: the up end is the higher label.
// Assumes: fields are stable while hop_valid is high; all compares unsigned.
module udr_hop_classify
    import udr_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int LVL_W = 4,
    parameter int LBL_W = 6
) (
    input  logic             dir_mode,
    input  logic [ID_W-1:0]  src_id,
    input  logic [ID_W-1:0]  dst_id,
    input  logic [LVL_W-1:0] src_lvl,
    input  logic [LVL_W-1:0] dst_lvl,
    input  logic [LBL_W-1:0] src_lbl,
    input  logic [LBL_W-1:0] dst_lbl,
    output hop_dir_e         hop_dir
);
    logic lvl_up;
    logic lbl_up;

    // Level scheme: nearer the root wins, identifier breaks ties.
    always_comb begin
        if (dst_lvl < src_lvl)
            lvl_up = 1'b1;
        else if (dst_lvl == src_lvl)
            lvl_up = (dst_id < src_id);
        else
            lvl_up = 1'b0;
    end

    // Label scheme: the higher label is the up end.
    always_comb lbl_up = (dst_lbl > src_lbl);

    // Pick the scheme selected by dir_mode.
    always_comb hop_dir = (dir_mode ? lbl_up : lvl_up) ? HOP_UP : HOP_DOWN;

    // R2: in level mode an up hop never enters a deeper switch.
    always_comb
        a_r2_up_not_deeper: assert (dir_mode || hop_dir != HOP_UP || dst_lvl <= src_lvl);
    // R4: in label mode an up hop never goes between equal labels.
    always_comb
        a_r4_up_needs_label_change: assert (!dir_mode || hop_dir != HOP_UP || dst_lbl != src_lbl);
endmodule

// File: rtl/udr_path_state.sv
// Module: udr_path_state
// Holds the per-path sticky bits (down seen, violation seen) and issues
// the verdict one cycle after path_end.
// Assumes: path_start takes effect before a hop of the same cycle, and
// a hop of the same cycle as path_end is counted in the verdict.
module udr_path_state
    import udr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     path_start,
    input  logic     hop_valid,
    input  hop_dir_e hop_dir,
    input  logic     path_end,
    output logic     legal,
    output logic     done
);
    logic down_seen_q, bad_q;
    logic base_down, base_bad;
    logic down_nx, bad_nx;

    // Next state of the sticky bits, start first, then the hop.
    always_comb begin
        base_down = path_start ? 1'b0 : down_seen_q;
        base_bad  = path_start ? 1'b0 : bad_q;
        down_nx   = base_down;
        bad_nx    = base_bad;
        if (hop_valid) begin
            bad_nx  = base_bad | ((hop_dir == HOP_UP) & base_down);
            down_nx = base_down | (hop_dir == HOP_DOWN);
        end
    end

    // Sticky bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_seen_q <= 1'b0;
            bad_q       <= 1'b0;
        end else begin
            down_seen_q <= down_nx;
            bad_q       <= bad_nx;
        end
    end

    // Verdict and done pulse, one cycle after path_end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            legal <= 1'b0;
        end else begin
            done <= path_end;
            if (path_end)
                legal <= ~bad_nx;
        end
    end

    // R1: a start without a hop leaves a clean path.
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        path_start && !hop_valid |=> !down_seen_q && !bad_q);
    // R5: an up hop after a down hop marks the path bad.
    a_r5_up_after_down: assert property (@(posedge clk) disable iff (!rst_n)
        hop_valid && hop_dir == HOP_UP && down_seen_q && !path_start |=> bad_q);
    // R6: a violation survives until the next start.
    a_r6_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_q && !path_start |=> bad_q);
    // R7: a zero-hop path is legal.
    a_r7_empty_legal: assert property (@(posedge clk) disable iff (!rst_n)
        path_start && path_end && !hop_valid |=> legal && done);
    // R8: done follows path_end by one cycle and only then.
    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        path_end |=> done);
    a_r8_done_only: assert property (@(posedge clk) disable iff (!rst_n)
        !path_end |=> !done && $stable(legal));
endmodule

// File: rtl/updown_route_checker.sv
// Module: updown_route_checker (top)
// Checks a framed sequence of hops against the up/down rule.
// Assumes: one path open at a time; labels are unique positive values.
module updown_route_checker
    import udr_pkg::*;
#(
    parameter int ID_W  = 6,
    parameter int LVL_W = 4,
    parameter int LBL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_mode,
    input  logic             path_start,
    input  logic             hop_valid,
    input  logic [ID_W-1:0]  src_id,
    input  logic [ID_W-1:0]  dst_id,
    input  logic [LVL_W-1:0] src_lvl,
    input  logic [LVL_W-1:0] dst_lvl,
    input  logic [LBL_W-1:0] src_lbl,
    input  logic [LBL_W-1:0] dst_lbl,
    input  logic             path_end,
    output logic             legal,
    output logic             done
);
    hop_dir_e hop_dir;

    udr_hop_classify #(.ID_W(ID_W), .LVL_W(LVL_W), .LBL_W(LBL_W)) u_classify (
        .dir_mode (dir_mode),
        .src_id   (src_id),
        .dst_id   (dst_id),
        .src_lvl  (src_lvl),
        .dst_lvl  (dst_lvl),
        .src_lbl  (src_lbl),
        .dst_lbl  (dst_lbl),
        .hop_dir  (hop_dir)
    );

    udr_path_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .path_start (path_start),
        .hop_valid  (hop_valid),
        .hop_dir    (hop_dir),
        .path_end   (path_end),
        .legal      (legal),
        .done       (done)
    );
endmodule

// File: tb/updown_route_checker_tb_top.sv
module updown_route_checker_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_mode = 1'b0, path_start = 1'b0, hop_valid = 1'b0, path_end = 1'b0;
    logic [5:0] src_id = '0, dst_id = '0, src_lbl = '0, dst_lbl = '0;
    logic [3:0] src_lvl = '0, dst_lvl = '0;
    logic legal, done;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    updown_route_checker dut_i (
        .clk(clk), .rst_n(rst_n), .dir_mode(dir_mode), .path_start(path_start),
        .hop_valid(hop_valid), .src_id(src_id), .dst_id(dst_id),
        .src_lvl(src_lvl), .dst_lvl(dst_lvl), .src_lbl(src_lbl), .dst_lbl(dst_lbl),
        .path_end(path_end), .legal(legal), .done(done)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic exp_up(input logic m, input logic [5:0] fi, ti,
                                    input logic [3:0] fl, tl, input logic [5:0] fb, tb);
        if (m) return tb > fb;
        if (tl != fl) return tl < fl;
        return ti < fi;
    endfunction

    // Drive one cycle with the given controls and hop fields.
    task automatic cyc(input logic st, hv, en, input logic [5:0] fi, ti,
                       input logic [3:0] fl, tl, input logic [5:0] fb, tb);
        @(negedge clk);
        path_start = st; hop_valid = hv; path_end = en;
        src_id = fi; dst_id = ti; src_lvl = fl; dst_lvl = tl; src_lbl = fb; dst_lbl = tb;
        @(negedge clk);
        path_start = 1'b0; hop_valid = 1'b0; path_end = 1'b0;
    endtask

    // Level-mode hops: down (deeper) and up (shallower).
    task automatic hop_dn(); cyc(0, 1, 0, 6'd1, 6'd2, 4'd1, 4'd2, 6'd0, 6'd0); endtask
    task automatic hop_upw(); cyc(0, 1, 0, 6'd1, 6'd2, 4'd2, 4'd1, 6'd0, 6'd0); endtask
    task automatic open_p(); cyc(1, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    // Close and check verdict; done visible after this call, gone next cycle.
    task automatic close_p(input string req, input logic exp);
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0);
        check(req, done, 1'b1);
        check(req, legal, exp);
        @(negedge clk);
        check("R8", done, 1'b0);
        check("R8", legal, exp);
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++; if (done !== 1'b0 || legal !== 1'b0) begin
            n_bad++; $display("FAIL R10 actual=%b%b expected=00", done, legal);
        end
        rst_n = 1'b1;
        // R10: reset leaves no down recorded, so a lone up hop is legal
        open_p(); hop_upw(); close_p("R10", 1'b1);
        // R7 zero-hop paths, separate and single-cycle
        open_p(); close_p("R7", 1'b1);
        cyc(1, 0, 1, 0, 0, 0, 0, 0, 0);
        check("R7", done, 1'b1); check("R7", legal, 1'b1);
        // R5 ups then downs legal; down then up illegal
        open_p(); hop_upw(); hop_upw(); hop_dn(); hop_dn(); close_p("R5", 1'b1);
        open_p(); hop_dn(); hop_upw(); close_p("R5", 1'b0);
        // R6 sticky after further downs
        open_p(); hop_dn(); hop_upw(); hop_dn(); hop_dn(); close_p("R6", 1'b0);
        // R1 start clears a bad path; new path of only ups is legal
        open_p(); hop_upw(); close_p("R1", 1'b1);
        open_p(); hop_dn(); open_p(); hop_upw(); close_p("R1", 1'b1);
        // R9 hop with path_end counted; hop with path_start starts new path
        open_p(); hop_dn(); cyc(0, 1, 1, 6'd1, 6'd2, 4'd2, 4'd1, 0, 0);
        check("R9", done, 1'b1); check("R9", legal, 1'b0);
        hop_dn(); cyc(1, 1, 0, 6'd1, 6'd2, 4'd2, 4'd1, 0, 0); close_p("R9", 1'b1);
        // R2 R3 R4 sweeps: down hop then swept hop; legal iff swept hop is down
        for (int m = 0; m < 2; m++) begin
            dir_mode = m[0];
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    logic [5:0] fi, ti, fb, tb;
                    logic [3:0] fl, tl;
                    logic up;
                    fi = {4'd0, a[1:0]} * 6'd21; ti = {4'd0, b[1:0]} * 6'd21;
                    fl = a[5:2]; tl = b[5:2];
                    fb = a[5:0]; tb = b[5:0];
                    if (m == 0) begin
                        fb = 6'd0; tb = 6'd0;
                    end
                    up = exp_up(m[0], fi, ti, fl, tl, fb, tb);
                    open_p();
                    // known down hop in either scheme
                    cyc(0, 1, 0, 6'd5, 6'd6, 4'd3, 4'd4, 6'd9, 6'd8);
                    cyc(0, 1, 1, fi, ti, fl, tl, fb, tb);
                    if (m == 1) check("R4", legal, !up);
                    else if (fl == tl) check("R3", legal, !up);
                    else check("R2", legal, !up);
                end
            end
        end
        // R8 legal holds through idle cycles
        dir_mode = 1'b0;
        open_p(); hop_dn(); hop_upw(); close_p("R8", 1'b0);
        repeat (3) @(negedge clk);
        check("R8", legal, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule